// File: doc/BRIEF.md
# Machine-Mode Trap Controller

This unit owns the machine-mode exception state of a small 32-bit RISC-V core: the trap vector, the saved exception PC, the trap cause, the trap value and the scratch register. The pipeline reports faults from three places: instruction fetch, decode and the memory stage. Each report is a valid bit and a cause code. The unit also raises faults of its own when the CSR port is aimed at an address it does not hold, and when the core has no compressed support and the PC is not word aligned.

Faults are not taken at once. The first one seen during an instruction is latched and taken when the core signals that the instruction has retired. In that cycle the unit puts out the next PC. That PC is the trap handler address, the saved PC for a return, or the PC plus 4 (or plus 2 for a compressed instruction). If no trap vector has been written since reset, a trap stops the core and `halted` stays high until reset. While the fetch stage reports an access fault, the fetched word is replaced with a no-op, so the pipeline carries harmless bits up to the trap.

Top module: `mtrap_unit`

## Requirements
- R1: After reset all five CSRs (trap vector 0x305, scratch 0x340, saved PC 0x341, cause 0x342, trap value 0x343) read as zero, and `halted` is low.
- R2: A fault taken with a handler installed writes the cause code to 0x342 and `cur_pc` to 0x341, and clears 0x343 to zero.
- R3: The trap vector register reads back as written. Its bits [1:0] are the mode and the rest is the base. In mode 0, 2 or 3 a trap sets `pc_next` to the base with bits [1:0] cleared, and raises `pc_redirect`.
- R4: In mode 1 a trap sets `pc_next` to base + 4 × cause. Bit 31 of the cause is cleared before the multiply. The CSR still stores the full cause.
- R5: If no CSR write to 0x305 has happened since reset, a trap keeps `pc_redirect` low and sets `halted` after that edge. `halted` stays high until reset, and no later trap or return redirects.
- R6: A fault reported before `inst_done` gives no redirect in its own cycle. It is held and taken in the `inst_done` cycle. After that cycle the held fault is cleared.
- R7: Only the first fault of an instruction is kept. Among faults reported in the same cycle, fetch beats decode and decode beats memory.
- R8: When `inst_done` is high with no fault and no return, `pc_next` is `cur_pc` + 4, or + 2 when `inst_compressed` is high, and `pc_redirect` is low. `pc_redirect` is never high outside an `inst_done` cycle.
- R9: When `inst_done` and `mret_req` are both high with no fault, `pc_next` is the saved PC and `pc_redirect` is high. A fault in the same cycle wins over the return.
- R10: A CSR access (`csr_en`) to an address other than the five above raises an illegal-instruction fault (cause 2), ranked with decode. A write to such an address changes nothing.
- R11: With `HAS_C` = 0, a `cur_pc` whose bits [1:0] are not zero raises cause 0, ranked with fetch.
- R12: `fetch_word_out` is 0x00000013 while `fetch_req` is high, and equals `fetch_word_in` otherwise.
- R13: While `halted` is high, CSR writes have no effect. Reads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | XLEN | PC of the instruction in flight |
| inst_done | input | 1 | The instruction in flight retires this cycle |
| inst_compressed | input | 1 | The instruction in flight is 16 bits wide |
| mret_req | input | 1 | The retiring instruction is a trap return |
| fetch_req | input | 1 | Fetch-stage fault report |
| fetch_cause | input | XLEN | Cause code of the fetch fault |
| dec_req | input | 1 | Decode-stage fault report |
| dec_cause | input | XLEN | Cause code of the decode fault |
| mem_req | input | 1 | Memory-stage fault report |
| mem_cause | input | XLEN | Cause code of the memory fault |
| fetch_word_in | input | XLEN | Instruction word from fetch |
| fetch_word_out | output | XLEN | Instruction word passed on, or a no-op during a fetch fault |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| pc_next | output | XLEN | Next PC, valid in `inst_done` cycles |
| pc_redirect | output | 1 | `pc_next` is a trap or return target |
| halted | output | 1 | Trap taken with no handler installed |

## Verification
The bench builds the unit with `XLEN` = 32 and `HAS_C` = 0. The narrow instruction setting makes a misaligned `cur_pc` a fault source, so the cause-0 path can be reached. The compressed step of 2 can still be driven from an aligned PC. Vectored mode is driven with a cause whose bit 31 is set, which shows that only the low bits scale the offset. Faults are spread over several cycles of one instruction, and three are raised together, so both the first-kept rule and the same-cycle ranking are observed. The bench also reaches the no-handler halt and shows that CSR writes do nothing after it.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int CSR_AW = 12;

    typedef enum logic [CSR_AW-1:0] {
        CSR_TVEC    = 12'h305,
        CSR_SCRATCH = 12'h340,
        CSR_EPC     = 12'h341,
        CSR_CAUSE   = 12'h342,
        CSR_TVAL    = 12'h343
    } csr_sel_e;

    typedef enum logic [1:0] {
        TV_DIRECT  = 2'd0,
        TV_VECTOR  = 2'd1,
        TV_RSVD2   = 2'd2,
        TV_RSVD3   = 2'd3
    } tvec_mode_e;

    // Fault sources, lower index wins when reported together
    localparam int SRC_FETCH  = 0;
    localparam int SRC_DECODE = 1;
    localparam int SRC_MEM    = 2;
    localparam int NSRC       = 3;

    localparam int CAUSE_MISALIGN_FETCH = 0;
    localparam int CAUSE_ILLEGAL        = 2;

    localparam logic [31:0] NOP_WORD = 32'h0000_0013;

endpackage

// File: rtl/mtrap_arbiter.sv
module mtrap_arbiter #(
    parameter int XLEN = 32,
    parameter int NSRC = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0][XLEN-1:0]  cause,
    input  logic                       clear,
    output logic                       valid_o,
    output logic [XLEN-1:0]            cause_o
);
    logic            pend_v;
    logic [XLEN-1:0] pend_c;
    logic            new_v;
    logic [XLEN-1:0] new_c;

    // Lowest-numbered source wins among same-cycle reports
    always_comb begin
        new_v = 1'b0;
        new_c = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                new_v = 1'b1;
                new_c = cause[i];
            end
        end
    end

    assign valid_o = pend_v | new_v;
    assign cause_o = pend_v ? pend_c : new_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_c <= '0;
        end else if (clear) begin
            pend_v <= 1'b0;
            pend_c <= '0;
        end else if (!pend_v && new_v) begin
            pend_v <= 1'b1;
            pend_c <= new_c;
        end
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !clear) |=> (pend_v && $stable(pend_c)));

    // R6
    pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pend_v);

endmodule

// File: rtl/mtrap_csrs.sv
module mtrap_csrs
    import mtrap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_we,
    input  logic [CSR_AW-1:0] port_addr,
    input  logic [XLEN-1:0]   port_wdata,
    input  logic              trap_we,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [XLEN-1:0]   trap_pc,
    output logic [XLEN-1:0]   rdata,
    output logic              known,
    output logic [XLEN-1:0]   tvec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              installed_o
);
    logic [XLEN-1:0] tvec_q, scratch_q, epc_q, cause_q, tval_q;
    logic            inst_q;

    always_comb begin
        known = 1'b1;
        rdata = '0;
        case (port_addr)
            CSR_TVEC:    rdata = tvec_q;
            CSR_SCRATCH: rdata = scratch_q;
            CSR_EPC:     rdata = epc_q;
            CSR_CAUSE:   rdata = cause_q;
            CSR_TVAL:    rdata = tval_q;
            default:     known = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tvec_q    <= '0;
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            tval_q    <= '0;
            inst_q    <= 1'b0;
        end else begin
            if (port_we) begin
                case (port_addr)
                    CSR_TVEC: begin
                        tvec_q <= port_wdata;
                        inst_q <= 1'b1;
                    end
                    CSR_SCRATCH: scratch_q <= port_wdata;
                    CSR_EPC:     epc_q     <= port_wdata;
                    CSR_CAUSE:   cause_q   <= port_wdata;
                    CSR_TVAL:    tval_q    <= port_wdata;
                    default: ;
                endcase
            end
            // Trap updates take precedence over a same-cycle port write
            if (trap_we) begin
                cause_q <= trap_cause;
                epc_q   <= trap_pc;
                tval_q  <= '0;
            end
        end
    end

    assign tvec_o      = tvec_q;
    assign epc_o       = epc_q;
    assign installed_o = inst_q;

    // R2
    trap_tval_clr_chk: assert property (@(posedge clk) disable iff (rst)
        trap_we |=> (tval_q == '0));

    // R2
    trap_epc_chk: assert property (@(posedge clk) disable iff (rst)
        trap_we |=> (epc_q == $past(trap_pc)));

    // R5
    installed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        inst_q |=> inst_q);

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter bit HAS_C = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              inst_done,
    input  logic              inst_compressed,
    input  logic              mret_req,
    input  logic              fetch_req,
    input  logic [XLEN-1:0]   fetch_cause,
    input  logic              dec_req,
    input  logic [XLEN-1:0]   dec_cause,
    input  logic              mem_req,
    input  logic [XLEN-1:0]   mem_cause,
    input  logic [XLEN-1:0]   fetch_word_in,
    output logic [XLEN-1:0]   fetch_word_out,
    input  logic              csr_en,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [XLEN-1:0]   pc_next,
    output logic              pc_redirect,
    output logic              halted
);
    localparam logic [XLEN-1:0] STEP_FULL  = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
    localparam logic [XLEN-1:0] NOP        = XLEN'(NOP_WORD);

    logic                       halted_q;
    logic                       misal;
    logic [NSRC-1:0]            src_req;
    logic [NSRC-1:0][XLEN-1:0]  src_cause;
    logic                       eff_v;
    logic [XLEN-1:0]            eff_cause;
    logic                       csr_known;
    logic                       csr_bad;
    logic [XLEN-1:0]            tvec, epc;
    logic                       installed;
    logic                       take;
    logic [XLEN-1:0]            tvec_base;
    tvec_mode_e                 tvec_mode;
    logic [XLEN-1:0]            trap_target;

    generate
        if (HAS_C) begin : g_c
            assign misal = 1'b0;
        end else begin : g_noc
            assign misal = |cur_pc[1:0];
        end
    endgenerate

    assign csr_bad = csr_en && !csr_known;

    always_comb begin
        src_req   = '0;
        src_cause = '0;
        src_req[SRC_FETCH]    = !halted_q && (misal || fetch_req);
        src_cause[SRC_FETCH]  = misal ? XLEN'(CAUSE_MISALIGN_FETCH) : fetch_cause;
        src_req[SRC_DECODE]   = !halted_q && (dec_req || csr_bad);
        src_cause[SRC_DECODE] = dec_req ? dec_cause : XLEN'(CAUSE_ILLEGAL);
        src_req[SRC_MEM]      = !halted_q && mem_req;
        src_cause[SRC_MEM]    = mem_cause;
    end

    mtrap_arbiter #(.XLEN(XLEN), .NSRC(NSRC)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (src_req),
        .cause   (src_cause),
        .clear   (inst_done),
        .valid_o (eff_v),
        .cause_o (eff_cause)
    );

    assign take = inst_done && eff_v && !halted_q;

    mtrap_csrs #(.XLEN(XLEN)) u_csrs (
        .clk         (clk),
        .rst         (rst),
        .port_we     (csr_en && csr_we && !halted_q),
        .port_addr   (csr_addr),
        .port_wdata  (csr_wdata),
        .trap_we     (take),
        .trap_cause  (eff_cause),
        .trap_pc     (cur_pc),
        .rdata       (csr_rdata),
        .known       (csr_known),
        .tvec_o      (tvec),
        .epc_o       (epc),
        .installed_o (installed)
    );

    assign tvec_base = {tvec[XLEN-1:2], 2'b00};
    assign tvec_mode = tvec_mode_e'(tvec[1:0]);

    // Vectored offset: cause with bit 31 dropped, times four
    always_comb begin
        if (tvec_mode == TV_VECTOR)
            trap_target = tvec_base + {eff_cause[XLEN-3:0], 2'b00};
        else
            trap_target = tvec_base;
    end

    always_comb begin
        pc_redirect = 1'b0;
        pc_next     = cur_pc + (inst_compressed ? STEP_SHORT : STEP_FULL);
        if (halted_q) begin
            pc_next = cur_pc;
        end else if (take) begin
            pc_next     = installed ? trap_target : cur_pc;
            pc_redirect = installed;
        end else if (inst_done && mret_req) begin
            pc_next     = epc;
            pc_redirect = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            halted_q <= 1'b0;
        else if (take && !installed)
            halted_q <= 1'b1;
    end

    assign halted         = halted_q;
    assign fetch_word_out = fetch_req ? NOP : fetch_word_in;

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q);

    // R13
    halted_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> ($stable(tvec) && $stable(epc)));

    // R8
    redirect_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> inst_done);

    // R5
    halted_no_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        halted_q |-> !pc_redirect);

endmodule

// File: tb/tb_mtrap_unit.sv
module tb_mtrap_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [XLEN-1:0] cur_pc;
    logic            inst_done, inst_compressed, mret_req;
    logic            fetch_req, dec_req, mem_req;
    logic [XLEN-1:0] fetch_cause, dec_cause, mem_cause;
    logic [XLEN-1:0] fetch_word_in, fetch_word_out;
    logic            csr_en, csr_we;
    logic [11:0]     csr_addr;
    logic [XLEN-1:0] csr_wdata, csr_rdata;
    logic [XLEN-1:0] pc_next;
    logic            pc_redirect, halted;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mtrap_unit #(.XLEN(XLEN), .HAS_C(1'b0)) dut (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .inst_done(inst_done),
        .inst_compressed(inst_compressed), .mret_req(mret_req),
        .fetch_req(fetch_req), .fetch_cause(fetch_cause),
        .dec_req(dec_req), .dec_cause(dec_cause),
        .mem_req(mem_req), .mem_cause(mem_cause),
        .fetch_word_in(fetch_word_in), .fetch_word_out(fetch_word_out),
        .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .pc_next(pc_next), .pc_redirect(pc_redirect), .halted(halted)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        inst_done = 0; inst_compressed = 0; mret_req = 0;
        fetch_req = 0; dec_req = 0; mem_req = 0;
        fetch_cause = 0; dec_cause = 0; mem_cause = 0;
        fetch_word_in = 0; csr_en = 0; csr_we = 0; csr_addr = 0; csr_wdata = 0;
    endtask

    task automatic do_reset();
        idle();
        cur_pc = 0;
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        tick();
        csr_en = 0; csr_we = 0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [XLEN-1:0] d);
        csr_en = 1; csr_we = 0; csr_addr = a;
        #1 d = csr_rdata;
        csr_en = 0;
    endtask

    task automatic t_reset();
        logic [XLEN-1:0] v;
        do_reset();
        csr_rd(12'h305, v); check("R1 tvec", v, 0);
        csr_rd(12'h340, v); check("R1 scratch", v, 0);
        csr_rd(12'h341, v); check("R1 epc", v, 0);
        csr_rd(12'h342, v); check("R1 cause", v, 0);
        csr_rd(12'h343, v); check("R1 tval", v, 0);
        check("R1 halted", halted, 0);
    endtask

    task automatic t_sequential();
        do_reset();
        cur_pc = 32'h100; inst_done = 1;
        #1 check("R8 next +4", pc_next, 32'h104);
        check("R8 no redirect", pc_redirect, 0);
        inst_compressed = 1;
        #1 check("R8 next +2", pc_next, 32'h102);
        tick();
        idle();
        #1 check("R8 redirect only on done", pc_redirect, 0);
    endtask

    task automatic t_direct();
        logic [XLEN-1:0] v;
        do_reset();
        csr_wr(12'h305, 32'h0000_1003);
        csr_wr(12'h343, 32'h55);
        csr_rd(12'h305, v); check("R3 tvec readback", v, 32'h1003);
        cur_pc = 32'h200; dec_req = 1; dec_cause = 3;
        #1 check("R6 no redirect before done", pc_redirect, 0);
        tick();
        dec_req = 0; inst_done = 1;
        #1 check("R3 direct target", pc_next, 32'h1000);
        check("R3 redirect", pc_redirect, 1);
        tick();
        idle();
        csr_rd(12'h342, v); check("R2 cause", v, 3);
        csr_rd(12'h341, v); check("R2 epc", v, 32'h200);
        csr_rd(12'h343, v); check("R2 tval cleared", v, 0);
    endtask

    task automatic t_vector();
        logic [XLEN-1:0] v;
        do_reset();
        csr_wr(12'h305, 32'h0000_2001);
        cur_pc = 32'h300; mem_req = 1; mem_cause = 32'h8000_0003; inst_done = 1;
        #1 check("R4 vectored strips bit31", pc_next, 32'h200C);
        tick();
        idle();
        csr_rd(12'h342, v); check("R4 full cause stored", v, 32'h8000_0003);
    endtask

    task automatic t_priority();
        logic [XLEN-1:0] v;
        do_reset();
        csr_wr(12'h305, 32'h0000_2001);
        cur_pc = 32'h400;
        fetch_req = 1; fetch_cause = 1; dec_req = 1; dec_cause = 2;
        mem_req = 1; mem_cause = 5; inst_done = 1;
        #1 check("R7 fetch wins", pc_next, 32'h2004);
        tick();
        idle();
        csr_rd(12'h342, v); check("R7 cause fetch", v, 1);
        mem_req = 1; mem_cause = 7;
        tick();
        mem_req = 0; fetch_req = 1; fetch_cause = 1; inst_done = 1;
        #1 check("R7 first kept target", pc_next, 32'h201C);
        tick();
        idle();
        csr_rd(12'h342, v); check("R7 first kept cause", v, 7);
    endtask

    task automatic t_mret();
        logic [XLEN-1:0] v;
        do_reset();
        csr_wr(12'h305, 32'h0000_1000);
        csr_wr(12'h341, 32'h0000_0400);
        cur_pc = 32'h500; mret_req = 1; inst_done = 1;
        #1 check("R9 return target", pc_next, 32'h400);
        check("R9 return redirect", pc_redirect, 1);
        tick();
        mret_req = 1; inst_done = 1; dec_req = 1; dec_cause = 2;
        #1 check("R9 fault beats return", pc_next, 32'h1000);
        tick();
        idle();
        csr_rd(12'h341, v); check("R9 epc overwritten", v, 32'h500);
    endtask

    task automatic t_badcsr();
        logic [XLEN-1:0] v;
        do_reset();
        csr_wr(12'h305, 32'h0000_1000);
        cur_pc = 32'h600; csr_en = 1; csr_we = 1; csr_addr = 12'h7C0;
        csr_wdata = 32'hFFFF_FFFF; inst_done = 1;
        #1 check("R10 unknown csr traps", pc_redirect, 1);
        check("R10 unknown csr target", pc_next, 32'h1000);
        tick();
        idle();
        csr_rd(12'h342, v); check("R10 illegal cause", v, 2);
        csr_rd(12'h305, v); check("R10 tvec untouched", v, 32'h1000);
        cur_pc = 32'h604; inst_done = 1;
        #1 check("R6 held fault cleared", pc_next, 32'h608);
        check("R6 no stale redirect", pc_redirect, 0);
        tick();
        idle();
    endtask

    task automatic t_misalign();
        logic [XLEN-1:0] v;
        do_reset();
        csr_wr(12'h305, 32'h0000_2001);
        cur_pc = 32'h102; inst_done = 1;
        #1 check("R11 misaligned target", pc_next, 32'h2000);
        check("R11 misaligned redirect", pc_redirect, 1);
        tick();
        idle();
        cur_pc = 32'h2000;
        csr_rd(12'h342, v); check("R11 cause zero", v, 0);
        csr_rd(12'h341, v); check("R11 epc", v, 32'h102);
    endtask

    task automatic t_nop();
        do_reset();
        fetch_word_in = 32'hDEAD_BEEF;
        #1 check("R12 passthrough", fetch_word_out, 32'hDEAD_BEEF);
        fetch_req = 1; fetch_cause = 1;
        #1 check("R12 nop substituted", fetch_word_out, 32'h13);
        idle();
    endtask

    task automatic t_nohandler();
        logic [XLEN-1:0] v;
        do_reset();
        cur_pc = 32'h700; dec_req = 1; dec_cause = 2; inst_done = 1;
        #1 check("R5 no redirect", pc_redirect, 0);
        tick();
        idle();
        #1 check("R5 halted", halted, 1);
        csr_rd(12'h342, v); check("R5 cause", v, 2);
        csr_rd(12'h341, v); check("R5 epc", v, 32'h700);
        tick(); tick(); tick();
        check("R5 halt held", halted, 1);
        csr_wr(12'h340, 32'h1234);
        csr_rd(12'h340, v); check("R13 write ignored", v, 0);
        csr_wr(12'h305, 32'h1000);
        mret_req = 1; inst_done = 1;
        #1 check("R5 no redirect when halted", pc_redirect, 0);
        tick();
        idle();
        check("R5 still halted", halted, 1);
    endtask

    initial begin
        idle();
        cur_pc = 0;
        rst = 1;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_direct();
        t_vector();
        t_priority();
        t_mret();
        t_badcsr();
        t_misalign();
        t_nop();
        t_nohandler();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule